// File: doc/BRIEF.md
# Accumulator OR and Move Execute Unit

This unit runs a small slice of an accumulator-style datapath that uses 14-bit instruction words. It holds an 8-bit accumulator (W), a bank of 128 eight-bit storage registers and a single zero flag. On each clock cycle with the valid strobe high, it decodes one instruction word and completes it within that cycle.

The unit recognises four operations. Two of them OR a value into the accumulator: either an immediate byte or the contents of a storage register. The other two are moves: an immediate byte into the accumulator, or a storage register passed through unchanged. Both storage-register operations carry a destination bit. That bit sends the result either to the accumulator or back to the addressed register. A move of a register back into itself therefore tests that value for zero and changes nothing else.

Any other word that arrives with the strobe raises an illegal flag in the same cycle and leaves all state untouched. A combinational debug port reads any storage register without side effects.

Top module: `orm_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears W, the zero flag and all 128 storage registers to zero.
- R2: A word with bits 13:8 = 6'b111000 ORs its low byte k into W (W <= W | k), and sets the zero flag exactly when the result is 0.
- R3: A word with bits 13:10 = 4'b1100 loads its low byte into W for any value of bits 9:8, and leaves the zero flag unchanged.
- R4: A word with bits 13:8 = 6'b000100 computes W | reg[a], where a = bits 6:0.
- R5: A word with bits 13:8 = 6'b001000 produces reg[a], where a = bits 6:0, unchanged.
- R6: For the two register operations, bit 7 = 0 writes the result to W and leaves every register unchanged, and bit 7 = 1 writes it to reg[a] and leaves W unchanged.
- R7: For the operations of R4 and R5, whichever the destination, the zero flag becomes 1 when the 8-bit result is 0 and 0 otherwise.
- R8: In a cycle with the valid strobe low, W, the zero flag and the registers keep their values.
- R9: With the valid strobe high, any word that matches none of the four patterns drives the illegal output high in that same cycle and changes no state. The illegal output is low in every other case.
- R10: The debug data output always equals reg[dbg_addr], combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word valid strobe |
| instr | input | 14 | Instruction word |
| dbg_addr | input | 7 | Debug read address |
| w_out | output | 8 | Accumulator W |
| z_out | output | 1 | Zero flag |
| illegal | output | 1 | Unrecognised word presented this cycle |
| dbg_data | output | 8 | Contents of the register at dbg_addr |

## Verification
The assertions check on every cycle that idle and illegal cycles hold W and the zero flag. They also check that the immediate load keeps the flag, that the immediate OR and the register move produce the right accumulator value and flag, and that a register-destination operation keeps W. Only the bench scenarios can show the state of the whole register bank: that reset clears it, that write-back lands only at the addressed location, and that a self-move leaves the stored value intact. The bench runs every immediate value, every register address with both destinations, every unused opcode prefix, and both fixed examples (0x9A | 0x35 = 0xBF and 0x13 | 0x91 = 0x93).

// File: rtl/orm_exec_unit.sv
module orm_exec_unit #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  input  logic [13:0]   instr,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] w_out,
  output logic          z_out,
  output logic          illegal,
  output logic [DW-1:0] dbg_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] regs [DEPTH];
  logic [DW-1:0] w_q;
  logic          z_q;

  logic [DW-1:0] lit;
  logic [AW-1:0] addr;
  logic          dst_reg;
  logic [DW-1:0] f_rd;
  logic          op_orl, op_movl, op_orf, op_movf, known;
  logic [DW-1:0] res;

  assign lit     = instr[DW-1:0];
  assign addr    = instr[AW-1:0];
  assign dst_reg = instr[7];
  assign f_rd    = regs[addr];

  assign op_orl  = instr[13:8]  == 6'b111000;
  assign op_movl = instr[13:10] == 4'b1100;
  assign op_orf  = instr[13:8]  == 6'b000100;
  assign op_movf = instr[13:8]  == 6'b001000;
  assign known   = op_orl | op_movl | op_orf | op_movf;

  always_comb begin
    res = f_rd;
    if (op_orl)       res = w_q | lit;
    else if (op_movl) res = lit;
    else if (op_orf)  res = w_q | f_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q <= '0;
      z_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (instr_valid && known) begin
      if ((op_orf || op_movf) && dst_reg) regs[addr] <= res;
      else                                w_q <= res;
      if (!op_movl) z_q <= (res == '0);
    end
  end

  assign w_out    = w_q;
  assign z_out    = z_q;
  assign illegal  = instr_valid && !known;
  assign dbg_data = regs[dbg_addr];

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(w_q) && $stable(z_q));

  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |=> $stable(w_q) && $stable(z_q));

  p_illegal_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> !illegal);

  p_movl_keeps_z_r3: assert property (@(posedge clk) disable iff (rst)
    instr_valid && op_movl |=> $stable(z_q) && w_q == $past(lit));

  p_orl_result_r2: assert property (@(posedge clk) disable iff (rst)
    instr_valid && op_orl |=> w_q == ($past(w_q) | $past(lit)) && z_q == (w_q == '0));

  p_movf_to_w_r5: assert property (@(posedge clk) disable iff (rst)
    instr_valid && op_movf && !dst_reg |=> w_q == $past(f_rd) && z_q == (w_q == '0));

  p_reg_dest_keeps_w_r6: assert property (@(posedge clk) disable iff (rst)
    instr_valid && (op_orf || op_movf) && dst_reg |=> $stable(w_q));

  p_orf_flag_r7: assert property (@(posedge clk) disable iff (rst)
    instr_valid && op_orf |=> z_q == (($past(w_q) | $past(f_rd)) == '0));
endmodule

// File: tb/orm_exec_unit_tb.sv
module orm_exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_valid = 1'b0;
  logic [13:0] instr = '0;
  logic [6:0] dbg_addr = '0;
  logic [7:0] w_out, dbg_data;
  logic z_out, illegal;

  int n_tests = 0;
  int n_fail = 0;

  logic [7:0] m_w;
  logic m_z;
  logic [7:0] m_mem [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  orm_exec_unit dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .dbg_addr(dbg_addr), .w_out(w_out), .z_out(z_out),
    .illegal(illegal), .dbg_data(dbg_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int kind(input logic [13:0] iw);
    if (iw[13:8] == 6'h38) return 1;
    if (iw[13:10] == 4'hC) return 2;
    if (iw[13:8] == 6'h04) return 3;
    if (iw[13:8] == 6'h08) return 4;
    return 0;
  endfunction

  task automatic exec(input logic [13:0] iw, input string req);
    int k;
    logic [7:0] r;
    logic [6:0] a;
    k = kind(iw);
    a = iw[6:0];
    @(negedge clk);
    instr = iw; instr_valid = 1'b1;
    #1;
    chk({req, " R9 illegal"}, int'(illegal), (k == 0) ? 1 : 0);
    @(posedge clk);
    case (k)
      1: begin r = m_w | iw[7:0]; m_w = r; m_z = (r == 0); end
      2: m_w = iw[7:0];
      3, 4: begin
        r = (k == 3) ? (m_w | m_mem[a]) : m_mem[a];
        if (iw[7]) m_mem[a] = r; else m_w = r;
        m_z = (r == 0);
      end
      default: ;
    endcase
    #1;
    instr_valid = 1'b0;
    dbg_addr = a;
    #1;
    chk({req, " W"}, int'(w_out), int'(m_w));
    chk({req, " Z R7"}, int'(z_out), int'(m_z));
    chk({req, " R6 reg"}, int'(dbg_data), int'(m_mem[a]));
  endtask

  function automatic logic [13:0] movl(input logic [7:0] k, input logic [1:0] dc);
    return {4'hC, dc, k};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_w = '0; m_z = 1'b0;
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    instr = 14'h3FFF;
    instr_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    instr_valid = 1'b0;
    #1;
    chk("R1 W reset", int'(w_out), 0);
    chk("R1 Z reset", int'(z_out), 0);
    for (int a = 0; a < 128; a++) begin
      dbg_addr = 7'(a);
      #1;
      chk("R1 R10 reg reset", int'(dbg_data), 0);
    end

    // R2 example: 0x9A | 0x35
    exec(movl(8'h9A, 2'b00), "R3 load");
    exec({6'h38, 8'h35}, "R2 or-imm");
    chk("R2 example W", int'(w_out), 8'hBF);
    chk("R2 example Z", int'(z_out), 0);

    // R4 example: reg 0x13 | W 0x91
    exec(movl(8'h13, 2'b11), "R3 load");
    exec({6'h04, 1'b1, 7'h20}, "R4 store");
    exec(movl(8'h91, 2'b01), "R3 load");
    exec({6'h04, 1'b0, 7'h20}, "R4 or-reg");
    chk("R4 example W", int'(w_out), 8'h93);
    chk("R4 example Z", int'(z_out), 0);

    // R5 zero register sets Z, then R3 keeps it
    exec({6'h08, 1'b0, 7'h21}, "R5 move zero");
    chk("R5 zero Z", int'(z_out), 1);
    exec(movl(8'h55, 2'b10), "R3 keep Z");
    chk("R3 Z kept", int'(z_out), 1);

    // R8 idle cycle with an OR word present
    @(negedge clk);
    instr = {6'h38, 8'hFF}; instr_valid = 1'b0;
    #1;
    chk("R8 R9 illegal idle", int'(illegal), 0);
    @(posedge clk); #1;
    chk("R8 W hold", int'(w_out), int'(m_w));
    chk("R8 Z hold", int'(z_out), int'(m_z));

    // R2 sweep of all immediates
    for (int k = 0; k < 256; k++) begin
      exec(movl(8'h00, 2'(k)), "R3 clear");
      exec({6'h38, 8'(k)}, "R2 sweep");
    end

    // R4 R6 fill every register with distinct values
    for (int a = 0; a < 128; a++) begin
      exec(movl(8'((a * 37 + 5) & 255), 2'(a)), "R3 sweep");
      exec({6'h04, 1'b1, 7'(a)}, "R4 R6 store");
    end

    // R5 R6 R7 move each register to W and to itself
    for (int a = 0; a < 128; a++) begin
      exec({6'h08, 1'b0, 7'(a)}, "R5 to W");
      exec(movl(8'hC3, 2'b00), "R3 set");
      exec({6'h08, 1'b1, 7'(a)}, "R5 R6 self");
      exec({6'h04, 1'b0, 7'(a)}, "R4 or-reg");
    end

    // R9 sweep of all 6-bit prefixes
    for (int p = 0; p < 64; p++) begin
      exec({6'(p), 8'(p * 5 + 1)}, "R9 prefix");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule